// File: doc/BRIEF.md
# Variable-Length Bitstream Read Port

This block lets a processor read bit fields of arbitrary alignment out of byte-addressed memory. Software loads a 24-bit byte address and a 4-bit bit offset through a small register port. The block then fetches three consecutive bytes starting at that address and treats them as a 24-bit little-endian window. The window is shifted right by the bit offset, and two read ports return the low and the high byte of the result.

The byte fetches go through a private decoder. It reaches ROM, work RAM and internal RAM only, so control registers can never be read through it. In advance mode, each read of the high port moves the stream forward by a programmed field length. When the position crosses a byte boundary, the block refetches the window on its own. Any register access made while a fetch is in progress is stalled with a wait signal.

Top module: `vbit_read_port`

## Requirements
- R1: After synchronous reset, `reg_wait` and `mem_req` are low, the bit offset is 0, advance mode is off, and both read ports return 0.
- R2: With window W = b[A] | b[A+1]<<8 | b[A+2]<<16 and bit offset S, a read of select 0 returns bits 7:0 of W>>S and a read of select 1 returns bits 15:8 of W>>S. The data is valid in the accepting cycle, with `reg_rd` high and `reg_wait` low.
- R3: The fetch decoder issues requests with `mem_tgt` codes as follows. Code 1 (ROM) covers banks 00-3F/80-BF offsets 8000-FFFF and all of banks C0-FF, with `mem_addr` equal to the raw address. Code 2 (work RAM) covers banks 00-3F/80-BF offsets 6000-7FFF and banks 40-4F, with `mem_addr` equal to the address modulo 2^WRAM_AW. Code 3 (internal RAM) covers banks 00-3F/80-BF offsets 0000-07FF and 3000-37FF, with `mem_addr` equal to the address modulo 2^IRAM_AW.
- R4: Any other byte address issues no request and contributes 0 to the window. This includes the register window at offsets 2200-23FF of banks 00-3F/80-BF.
- R5: A write to select 2 loads address bits 23:16, clears the bit offset and starts a three-byte prefetch. The block stays busy until the third byte is captured.
- R6: While a prefetch is in progress, any register read or write raises `reg_wait` and has no effect. It takes effect in the first cycle after the prefetch ends.
- R7: A write to select 3 loads the bit offset from data bits 3:0 and the field length code L-1 from bits 7:4. This changes the returned field immediately, without a refetch.
- R8: Writing select 5 turns advance mode off (select 4 turns it on). With advance mode off, reading the high port leaves the address and offset unchanged.
- R9: In advance mode, a high-port read returns the current field and then sets sum = offset + L. The offset becomes sum mod 8 and the address grows by sum/8 bytes. A refetch (with wait) happens only when sum/8 is non-zero.
- R10: Window byte addresses and advance steps wrap modulo 2^24.
- R11: `mem_req`, `mem_tgt` and `mem_addr` stay stable from the first cycle of a request until the cycle `mem_ack` is high.
- Writes to select 0 and 1 load address bits 7:0 and 15:8. They start no fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe (has priority over read) |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| reg_wait | output | 1 | Access stalled while a prefetch runs |
| mem_req | output | 1 | Fetch request |
| mem_tgt | output | 2 | Fetch target: 1 ROM, 2 work RAM, 3 internal RAM |
| mem_addr | output | 24 | Fetch address within the target |
| mem_ack | input | 1 | Fetch data valid on `mem_rdata` |
| mem_rdata | input | 8 | Fetched byte |

## Verification
On every cycle, the assertions check that requests occur only during a prefetch and never touch the register window. They also check that the WRAM and IRAM indices stay in range, that a request holds steady until it is acknowledged, that a top-byte address write leaves the block busy with offset 0, that a stalled write changes nothing, and that the offset stays below 8 after an advance. The field values themselves can only be shown by the bench's scenarios:
- the byte order of the window and the shift;
- the region mapping and the wrap across 24 bits;
- the byte carry of an advance;
- whether a refetch was triggered at all.

// File: rtl/vbr_pkg.sv
package vbr_pkg;
    localparam int ADDR_W    = 24;
    localparam int BYTE_W    = 8;
    localparam int WIN_BYTES = 3;
    localparam int WIN_W     = WIN_BYTES * BYTE_W;
    localparam int OFS_W     = 4;
    localparam int SEL_W     = 3;
    localparam int BYTE_SH   = $clog2(BYTE_W);

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [WIN_W-1:0]  win_t;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_ROM  = 2'd1,
        TGT_WRAM = 2'd2,
        TGT_IRAM = 2'd3
    } tgt_e;

    typedef struct packed {
        tgt_e  tgt;
        addr_t idx;
    } route_t;

    localparam logic [SEL_W-1:0] SEL_LO      = 3'd0;
    localparam logic [SEL_W-1:0] SEL_MID     = 3'd1;
    localparam logic [SEL_W-1:0] SEL_HI      = 3'd2;
    localparam logic [SEL_W-1:0] SEL_CFG     = 3'd3;
    localparam logic [SEL_W-1:0] SEL_ADV_ON  = 3'd4;
    localparam logic [SEL_W-1:0] SEL_ADV_OFF = 3'd5;

    function automatic logic in_region(addr_t a, addr_t mask, addr_t match);
        return (a & mask) == match;
    endfunction
endpackage

// File: rtl/vbr_decode.sv
module vbr_decode
    import vbr_pkg::*;
#(
    parameter int WRAM_AW = 18,
    parameter int IRAM_AW = 11
) (
    input  addr_t  addr,
    output route_t route
);
    localparam addr_t WRAM_MASK = addr_t'((64'd1 << WRAM_AW) - 64'd1);
    localparam addr_t IRAM_MASK = addr_t'((64'd1 << IRAM_AW) - 64'd1);

    logic is_rom, is_wram, is_iram;

    always_comb begin
        is_rom  = in_region(addr, 24'h408000, 24'h008000)
               || in_region(addr, 24'hC00000, 24'hC00000);
        is_wram = in_region(addr, 24'h40E000, 24'h006000)
               || in_region(addr, 24'hF00000, 24'h400000);
        is_iram = in_region(addr, 24'h40F800, 24'h000000)
               || in_region(addr, 24'h40F800, 24'h003000);
    end

    always_comb begin
        route = '{tgt: TGT_NONE, idx: '0};
        if (is_rom) begin
            route = '{tgt: TGT_ROM, idx: addr};
        end else if (is_wram) begin
            route = '{tgt: TGT_WRAM, idx: addr & WRAM_MASK};
        end else if (is_iram) begin
            route = '{tgt: TGT_IRAM, idx: addr & IRAM_MASK};
        end
    end
endmodule

// File: rtl/vbr_fetch.sv
module vbr_fetch
    import vbr_pkg::*;
#(
    parameter int WRAM_AW = 18,
    parameter int IRAM_AW = 11
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  addr_t       start_addr,
    output logic        busy,
    output win_t        window,
    output addr_t       fetch_addr,
    output logic        mem_req,
    output logic [1:0]  mem_tgt,
    output addr_t       mem_addr,
    input  logic        mem_ack,
    input  byte_t       mem_rdata
);
    localparam int IDX_W = $clog2(WIN_BYTES);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(WIN_BYTES - 1);

    logic [IDX_W-1:0] idx_q;
    logic             busy_q;
    addr_t            base_q;
    byte_t            lane_q [WIN_BYTES];
    route_t           route;
    logic             hit, take, last;
    byte_t            take_byte;

    assign fetch_addr = base_q + addr_t'(idx_q);

    vbr_decode #(.WRAM_AW(WRAM_AW), .IRAM_AW(IRAM_AW)) u_dec (
        .addr  (fetch_addr),
        .route (route)
    );

    assign hit       = route.tgt != TGT_NONE;
    assign take      = busy_q && (!hit || mem_ack);
    assign take_byte = hit ? mem_rdata : '0;
    assign last      = idx_q == IDX_LAST;

    assign mem_req  = busy_q && hit;
    assign mem_tgt  = route.tgt;
    assign mem_addr = route.idx;
    assign busy     = busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
            base_q <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
            base_q <= start_addr;
        end else if (take) begin
            if (last) begin
                busy_q <= 1'b0;
                idx_q  <= '0;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    for (genvar g = 0; g < WIN_BYTES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                lane_q[g] <= '0;
            end else if (take && idx_q == IDX_W'(g)) begin
                lane_q[g] <= take_byte;
            end
        end
        assign window[g*BYTE_W +: BYTE_W] = lane_q[g];
    end
endmodule

// File: rtl/vbr_pos.sv
module vbr_pos
    import vbr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [SEL_W-1:0]  sel,
    input  byte_t             wdata,
    output logic [OFS_W-1:0]  ofs,
    output logic              adv_en,
    output logic              start,
    output addr_t             start_addr
);
    localparam int SUM_W  = OFS_W + 1;
    localparam int STEP_W = SUM_W - BYTE_SH;

    addr_t             addr_q, addr_d;
    logic [OFS_W-1:0]  ofs_q, ofs_d, len_q, len_d;
    logic              adv_q, adv_d;
    logic [SUM_W-1:0]  sum;
    logic [STEP_W-1:0] step;
    logic              advance;

    assign sum     = SUM_W'(ofs_q) + SUM_W'(len_q) + SUM_W'(1);
    assign step    = sum[SUM_W-1:BYTE_SH];
    assign advance = rd_en && (sel == SEL_MID) && adv_q;

    always_comb begin
        addr_d = addr_q;
        ofs_d  = ofs_q;
        len_d  = len_q;
        adv_d  = adv_q;
        start  = 1'b0;
        if (wr_en) begin
            case (sel)
                SEL_LO:      addr_d[0*BYTE_W +: BYTE_W] = wdata;
                SEL_MID:     addr_d[1*BYTE_W +: BYTE_W] = wdata;
                SEL_HI: begin
                    addr_d[2*BYTE_W +: BYTE_W] = wdata;
                    ofs_d = '0;
                    start = 1'b1;
                end
                SEL_CFG: begin
                    ofs_d = wdata[OFS_W-1:0];
                    len_d = wdata[BYTE_W-1:OFS_W];
                end
                SEL_ADV_ON:  adv_d = 1'b1;
                SEL_ADV_OFF: adv_d = 1'b0;
                default: ;
            endcase
        end else if (advance) begin
            ofs_d  = OFS_W'(sum[BYTE_SH-1:0]);
            addr_d = addr_q + addr_t'(step);
            start  = step != '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            ofs_q  <= '0;
            len_q  <= '0;
            adv_q  <= 1'b0;
        end else begin
            addr_q <= addr_d;
            ofs_q  <= ofs_d;
            len_q  <= len_d;
            adv_q  <= adv_d;
        end
    end

    assign ofs        = ofs_q;
    assign adv_en     = adv_q;
    assign start_addr = addr_d;
endmodule

// File: rtl/vbit_read_port.sv
module vbit_read_port
    import vbr_pkg::*;
#(
    parameter int WRAM_AW = 18,
    parameter int IRAM_AW = 11
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_rd,
    input  logic        reg_wr,
    input  logic [2:0]  reg_sel,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    output logic        reg_wait,
    output logic        mem_req,
    output logic [1:0]  mem_tgt,
    output logic [23:0] mem_addr,
    input  logic        mem_ack,
    input  logic [7:0]  mem_rdata
);
    localparam int FIELD_W = 2 * BYTE_W;

    logic               busy, wr_en, rd_en, start, adv_w;
    logic [OFS_W-1:0]   ofs_w;
    addr_t              start_addr, fetch_addr;
    win_t               window;
    logic [FIELD_W-1:0] field;

    assign reg_wait = (reg_rd || reg_wr) && busy;
    assign wr_en    = reg_wr && !busy;
    assign rd_en    = reg_rd && !reg_wr && !busy;

    vbr_pos u_pos (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .sel        (reg_sel),
        .wdata      (reg_wdata),
        .ofs        (ofs_w),
        .adv_en     (adv_w),
        .start      (start),
        .start_addr (start_addr)
    );

    vbr_fetch #(.WRAM_AW(WRAM_AW), .IRAM_AW(IRAM_AW)) u_fetch (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .start_addr (start_addr),
        .busy       (busy),
        .window     (window),
        .fetch_addr (fetch_addr),
        .mem_req    (mem_req),
        .mem_tgt    (mem_tgt),
        .mem_addr   (mem_addr),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata)
    );

    assign field = FIELD_W'(window >> ofs_w);

    always_comb begin
        case (reg_sel)
            SEL_LO:  reg_rdata = field[BYTE_W-1:0];
            SEL_MID: reg_rdata = field[FIELD_W-1:BYTE_W];
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/vbit_read_port_chk.sv
module vbit_read_port_chk
    import vbr_pkg::*;
#(
    parameter int WRAM_AW = 18,
    parameter int IRAM_AW = 11
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_rd,
    input logic              reg_wr,
    input logic [2:0]        reg_sel,
    input logic              reg_wait,
    input logic              mem_req,
    input logic [1:0]        mem_tgt,
    input logic [23:0]       mem_addr,
    input logic              mem_ack,
    input logic              busy,
    input logic [OFS_W-1:0]  ofs,
    input logic              adv_en,
    input addr_t             fetch_addr
);
    localparam logic [23:0] WRAM_LIM = 24'((64'd1 << WRAM_AW));
    localparam logic [23:0] IRAM_LIM = 24'((64'd1 << IRAM_AW));

    AST_REQ_IN_PREFETCH: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy); // R5

    AST_REQ_NOT_REGS: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> ((fetch_addr & 24'h40FE00) != 24'h002200) && (mem_tgt != 2'd0)); // R4

    AST_WRAM_INDEX: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_tgt == 2'd2) |-> (mem_addr < WRAM_LIM)); // R3

    AST_IRAM_INDEX: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_tgt == 2'd3) |-> (mem_addr < IRAM_LIM)); // R3

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_tgt))); // R11

    AST_HI_WRITE_STARTS: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !reg_wait && reg_sel == SEL_HI) |=> (busy && ofs == '0)); // R5

    AST_STALLED_WRITE_INERT: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_wait) |=> $stable(ofs)); // R6

    AST_ADV_OFS_RANGE: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && !reg_wr && !reg_wait && reg_sel == SEL_MID && adv_en)
        |=> (ofs < OFS_W'(BYTE_W))); // R9
endmodule

bind vbit_read_port vbit_read_port_chk #(.WRAM_AW(WRAM_AW), .IRAM_AW(IRAM_AW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_rd     (reg_rd),
    .reg_wr     (reg_wr),
    .reg_sel    (reg_sel),
    .reg_wait   (reg_wait),
    .mem_req    (mem_req),
    .mem_tgt    (mem_tgt),
    .mem_addr   (mem_addr),
    .mem_ack    (mem_ack),
    .busy       (busy),
    .ofs        (ofs_w),
    .adv_en     (adv_w),
    .fetch_addr (fetch_addr)
);

// File: tb/vbit_read_port_test.sv
`timescale 1ns/1ps
module vbit_read_port_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_rd = 1'b0, reg_wr = 1'b0;
    logic [2:0]  reg_sel = 3'd0;
    logic [7:0]  reg_wdata = 8'd0;
    logic [7:0]  reg_rdata;
    logic        reg_wait;
    logic        mem_req;
    logic [1:0]  mem_tgt;
    logic [23:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [7:0]  mem_rdata = 8'd0;

    int checks = 0;
    int errors = 0;
    int bad_tgt = 0;
    int bad_hold = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    vbit_read_port uut (
        .clk(clk), .rst(rst), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_wait(reg_wait),
        .mem_req(mem_req), .mem_tgt(mem_tgt), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] rom_fn(logic [23:0] a);
        return a[7:0] + a[15:8] * 8'd3 + a[23:16] * 8'd7;
    endfunction
    function automatic logic [7:0] wram_fn(logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ {a[17:16], 6'h15};
    endfunction
    function automatic logic [7:0] iram_fn(logic [23:0] a);
        return a[7:0] ^ {5'h0, a[10:8]} ^ 8'hC3;
    endfunction

    // memory responder: one-cycle acknowledge
    always @(posedge clk) begin
        if (rst) begin
            mem_ack <= 1'b0;
        end else begin
            mem_ack <= mem_req && !mem_ack;
            case (mem_tgt)
                2'd1: mem_rdata <= rom_fn(mem_addr);
                2'd2: mem_rdata <= wram_fn(mem_addr);
                2'd3: mem_rdata <= iram_fn(mem_addr);
                default: mem_rdata <= 8'hEE;
            endcase
        end
    end

    // port monitors for R4 and R11
    logic        pend = 1'b0;
    logic [23:0] pend_addr = 24'd0;
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_req && mem_tgt == 2'd0) bad_tgt++;
            if (pend && (!mem_req || mem_addr != pend_addr)) bad_hold++;
            pend      <= mem_req && !mem_ack;
            pend_addr <= mem_addr;
        end
    end

    // reference model from the requirements
    function automatic logic [7:0] exp_byte(logic [23:0] a);
        if ((a & 24'h408000) == 24'h008000 || (a & 24'hC00000) == 24'hC00000)
            return rom_fn(a);
        if ((a & 24'h40E000) == 24'h006000 || (a & 24'hF00000) == 24'h400000)
            return wram_fn(a & 24'h03FFFF);
        if ((a & 24'h40F800) == 24'h000000 || (a & 24'h40F800) == 24'h003000)
            return iram_fn(a & 24'h0007FF);
        return 8'h00;
    endfunction
    function automatic logic [15:0] exp_field(logic [23:0] a, logic [3:0] s);
        logic [23:0] w;
        w = {exp_byte(a + 24'd2), exp_byte(a + 24'd1), exp_byte(a)};
        w = w >> s;
        return w[15:0];
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic access(input bit is_wr, input logic [2:0] sel, input logic [7:0] data,
                          output logic [7:0] rdata, output bit saw_wait);
        @(negedge clk);
        reg_wr = is_wr; reg_rd = !is_wr; reg_sel = sel; reg_wdata = data;
        saw_wait = 1'b0;
        #1;
        while (reg_wait) begin
            saw_wait = 1'b1;
            @(negedge clk);
            #1;
        end
        rdata = reg_rdata;
        @(posedge clk);
        #1;
        reg_wr = 1'b0; reg_rd = 1'b0;
    endtask

    task automatic wr(input logic [2:0] sel, input logic [7:0] data);
        logic [7:0] d; bit w;
        access(1'b1, sel, data, d, w);
    endtask

    task automatic rd(input logic [2:0] sel, output logic [7:0] d, output bit w);
        access(1'b0, sel, 8'h00, d, w);
    endtask

    task automatic set_addr(input logic [23:0] a);
        wr(3'd0, a[7:0]);
        wr(3'd1, a[15:8]);
        wr(3'd2, a[23:16]);
    endtask

    // {address, bit offset}
    localparam logic [27:0] VEC [10] = '{
        {24'h008000, 4'd0},
        {24'hC01234, 4'd5},
        {24'h006000, 4'd3},
        {24'h43FFFE, 4'd9},
        {24'h800100, 4'd15},
        {24'h3F37FE, 4'd4},
        {24'h0021FF, 4'd0},
        {24'hFFFFFF, 4'd12},
        {24'h3F7FFF, 4'd7},
        {24'h500000, 4'd1}
    };

    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements): actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0]  d;
        logic [15:0] f;
        bit          w;

        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;

        // R1 reset state
        check(reg_wait == 1'b0, "R1 wait after reset", 32'(reg_wait), 32'd0);
        check(mem_req == 1'b0, "R1 req after reset", 32'(mem_req), 32'd0);
        rd(3'd0, d, w);
        check(d == 8'h00, "R1 low port after reset", 32'(d), 32'd0);
        rd(3'd1, d, w);
        check(d == 8'h00, "R1 high port after reset", 32'(d), 32'd0);

        // table walk: R2 R3 R4 R10
        for (int i = 0; i < 10; i++) begin
            logic [23:0] a;
            logic [3:0]  s;
            a = VEC[i][27:4];
            s = VEC[i][3:0];
            set_addr(a);
            wr(3'd3, {4'h0, s});
            f = exp_field(a, s);
            rd(3'd0, d, w);
            check(d == f[7:0], "R2 R3 R4 R10 vector low", 32'(d), 32'(f[7:0]));
            rd(3'd1, d, w);
            check(d == f[15:8], "R2 R3 R4 R10 vector high", 32'(d), 32'(f[15:8]));
        end

        // R7 offset write takes effect without refetch
        set_addr(24'h008000);
        wr(3'd3, 8'h00);
        wr(3'd3, 8'h04);
        rd(3'd0, d, w);
        f = exp_field(24'h008000, 4'd4);
        check(w == 1'b0, "R7 no refetch on offset write", 32'(w), 32'd0);
        check(d == f[7:0], "R7 shifted low", 32'(d), 32'(f[7:0]));

        // R6 access during prefetch is stalled
        wr(3'd2, 8'h01);
        access(1'b1, 3'd3, 8'h02, d, w);
        check(w == 1'b1, "R6 wait during prefetch", 32'(w), 32'd1);
        rd(3'd0, d, w);
        f = exp_field(24'h018000, 4'd2);
        check(d == f[7:0], "R6 stalled write applied", 32'(d), 32'(f[7:0]));

        // R5 top-byte write clears offset
        wr(3'd3, 8'h09);
        wr(3'd2, 8'h01);
        rd(3'd0, d, w);
        f = exp_field(24'h018000, 4'd0);
        check(d == f[7:0], "R5 offset cleared", 32'(d), 32'(f[7:0]));

        // R9 advance mode
        set_addr(24'h008000);
        wr(3'd3, 8'h46);           // L=5, offset 6
        wr(3'd4, 8'h00);
        rd(3'd1, d, w);
        f = exp_field(24'h008000, 4'd6);
        check(d == f[15:8], "R9 high before advance", 32'(d), 32'(f[15:8]));
        rd(3'd0, d, w);
        f = exp_field(24'h008001, 4'd3);
        check(w == 1'b1, "R9 refetch on byte carry", 32'(w), 32'd1);
        check(d == f[7:0], "R9 advanced by one byte", 32'(d), 32'(f[7:0]));
        wr(3'd3, 8'h03);           // L=1, offset 3
        rd(3'd1, d, w);
        rd(3'd0, d, w);
        f = exp_field(24'h008001, 4'd4);
        check(w == 1'b0, "R9 no refetch without carry", 32'(w), 32'd0);
        check(d == f[7:0], "R9 offset only advance", 32'(d), 32'(f[7:0]));
        wr(3'd3, 8'hF4);           // L=16, offset 4
        rd(3'd1, d, w);
        rd(3'd0, d, w);
        f = exp_field(24'h008003, 4'd4);
        check(d == f[7:0], "R9 two byte advance", 32'(d), 32'(f[7:0]));

        // R10 advance wraps the address
        set_addr(24'hFFFFFE);
        wr(3'd3, 8'hF7);           // L=16, offset 7
        rd(3'd1, d, w);
        f = exp_field(24'hFFFFFE, 4'd7);
        check(d == f[15:8], "R10 high before wrap", 32'(d), 32'(f[15:8]));
        rd(3'd0, d, w);
        f = exp_field(24'h000000, 4'd7);
        check(d == f[7:0], "R10 wrapped advance", 32'(d), 32'(f[7:0]));

        // R8 advance off: high reads do not move
        wr(3'd5, 8'h00);
        set_addr(24'h40ABCD);
        wr(3'd3, 8'hF5);
        rd(3'd1, d, w);
        rd(3'd1, d, w);
        f = exp_field(24'h40ABCD, 4'd5);
        check(d == f[15:8], "R8 repeated high read", 32'(d), 32'(f[15:8]));
        rd(3'd0, d, w);
        check(w == 1'b0 && d == f[7:0], "R8 position unchanged", 32'(d), 32'(f[7:0]));

        // R4 and R11 port monitors
        check(bad_tgt == 0, "R4 no request without target", 32'(bad_tgt), 32'd0);
        check(bad_hold == 0, "R11 request held until ack", 32'(bad_hold), 32'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule